// File: doc/BRIEF.md
# Interrupt Message Byte Link

This block moves one interrupt message across a narrow 8-bit link. A message is a 16-bit header and a 128-bit data word. The header holds a 5-bit destination thread in bits 12:8 and a 5-bit originator identifier in bits 4:0. The other six header bits are reserved. The sending half takes a message on a ready/valid load port and plays it out as 18 consecutive bytes with a valid strobe. The two header bytes go first, upper half before lower half. The sixteen data bytes follow, most significant byte first, so the data word's bits 127:120 travel on the third beat and bits 7:0 on the last.

The receiving half counts valid bytes, not clock cycles, so gaps in its input stream only pause it. It rebuilds the frame and, in the cycle after the 18th byte, raises a one-cycle done pulse with the header and data word on its outputs. These outputs hold until the next frame completes. The reserved header bits are zero on the wire and are cleared again on the receiving side.

The transmitter state machine has three states:
- `TX_IDLE`: waiting for a message.
- `TX_HEAD`: sending beats 1 and 2.
- `TX_BODY`: sending beats 3 to 18.

Its transitions are:
- `TX_IDLE` to `TX_HEAD` on load.
- `TX_HEAD` to `TX_BODY` after the second header beat.
- `TX_BODY` to `TX_IDLE` after beat 18 when no message is offered.
- `TX_BODY` to `TX_HEAD` after beat 18 when a message is loaded in that same cycle, which starts a back-to-back frame.

The receiver state machine has two states:
- `RX_HEAD`: expecting header byte 1 or 2.
- `RX_BODY`: expecting data bytes.

Its transitions are:
- `RX_HEAD` to `RX_BODY` on the second valid byte.
- `RX_BODY` to `RX_HEAD` on the 18th valid byte.

Top module: `irq_byte_link`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) leaves ld_ready high, ser_valid low and rx_done low in the cycle after reset.
- R2: ld_ready is high when no frame is being sent and during beat 18 of a frame, and low on beats 1 to 17. A message is taken at an edge where ld_valid and ld_ready are both high.
- R3: ld_valid, ld_target, ld_source and ld_payload have no effect on ser_byte or ser_valid while ld_ready is low.
- R4: ser_valid starts in the cycle after a message is taken and stays high for exactly 18 consecutive cycles, unless another message is taken.
- R5: Beat 1 carries {3'b000, target} and beat 2 carries {3'b000, source`}, so the header is target in bits 12:8, source in bits 4:0, and zero in bits 15:13 and 7:5.
- R6: Beats 3 to 18 carry ld_payload bits 127:120, then 119:112, and so on down to bits 7:0.
- R7: A message taken during beat 18 makes its beat 1 appear in the very next cycle, with no idle cycle between the frames.
- R8: The receiver advances only on cycles with rx_valid high. A cycle with rx_valid low leaves its byte count unchanged.
- R9: rx_done is high for exactly one cycle, the cycle after the 18th valid received byte. In that cycle rx_payload equals data bytes 3 to 18 packed most significant first, and both outputs hold until the next done.
- R10: rx_header equals the two received header bytes with bits 15:13 and 7:5 forced to zero, whatever values those bits had on the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | A message is offered on the load port |
| ld_ready | output | 1 | The transmitter can take a message |
| ld_target | input | 5 | Destination thread of the offered message |
| ld_source | input | 5 | Originator identifier of the offered message |
| ld_payload | input | 128 | Data word of the offered message |
| ser_byte | output | 8 | Link byte being sent |
| ser_valid | output | 1 | ser_byte holds a frame byte this cycle |
| rx_byte | input | 8 | Link byte arriving at the receiver |
| rx_valid | input | 1 | rx_byte is valid this cycle |
| rx_done | output | 1 | One-cycle pulse: a full frame has been rebuilt |
| rx_header | output | 16 | Rebuilt header, reserved bits cleared |
| rx_payload | output | 128 | Rebuilt data word |

## Verification
The transmitter is loaded with several data patterns to tell byte-order faults from bit-order or field-swap faults:
- Counting bytes.
- All ones.
- A single set top bit.
- Extreme target and source values, which show whether the two fields are swapped or misplaced.

The load strobe is kept high through whole frames with different data on the port. This shows whether a load is wrongly taken mid-frame, and whether the load at beat 18 follows with no gap. The receiver is fed frames whose reserved header bits are all ones, and frames broken up by idle cycles at various beats. This separates counting bytes from counting cycles and shows whether the reserved bits are cleared.

// File: rtl/irq_link_pkg.sv
package irq_link_pkg;

    localparam int BYTE_W    = 8;
    localparam int HDR_BYTES = 2;
    localparam int HDR_W     = HDR_BYTES * BYTE_W;
    localparam int FLD_W     = 5;
    localparam int RSV_W     = BYTE_W - FLD_W;
    localparam logic [BYTE_W-1:0] HDR_KEEP = BYTE_W'((1 << FLD_W) - 1);

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_HEAD = 2'd1,
        TX_BODY = 2'd2
    } tx_state_t;

    typedef enum logic {
        RX_HEAD = 1'b0,
        RX_BODY = 1'b1
    } rx_state_t;

    function automatic logic [HDR_W-1:0] make_hdr(input logic [FLD_W-1:0] tgt,
                                                  input logic [FLD_W-1:0] src);
        return {{RSV_W{1'b0}}, tgt, {RSV_W{1'b0}}, src};
    endfunction

endpackage

// File: rtl/irq_ser_tx.sv
module irq_ser_tx
    import irq_link_pkg::*;
#(
    parameter int PAY_BYTES = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ld_valid,
    output logic                        ld_ready,
    input  logic [FLD_W-1:0]            ld_target,
    input  logic [FLD_W-1:0]            ld_source,
    input  logic [PAY_BYTES*BYTE_W-1:0] ld_payload,
    output logic [BYTE_W-1:0]           ser_byte,
    output logic                        ser_valid
);

    localparam int FRAME_BYTES = HDR_BYTES + PAY_BYTES;
    localparam int FRAME_W     = FRAME_BYTES * BYTE_W;
    localparam int CNT_W       = $clog2(FRAME_BYTES);
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(FRAME_BYTES - 1);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BYTES - 1);

    tx_state_t          state_q, state_d;
    logic [CNT_W-1:0]   beat_q;
    logic [FRAME_W-1:0] frame_q;
    logic               last_beat;
    logic               take;

    assign last_beat = (state_q == TX_BODY) && (beat_q == LAST_BEAT);
    assign ld_ready  = (state_q == TX_IDLE) || last_beat;
    assign take      = ld_valid && ld_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (take) state_d = TX_HEAD;
            TX_HEAD: if (beat_q == HDR_LAST) state_d = TX_BODY;
            TX_BODY: if (last_beat) state_d = take ? TX_HEAD : TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TX_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q  <= '0;
            frame_q <= '0;
        end else if (take) begin
            beat_q  <= '0;
            frame_q <= {make_hdr(ld_target, ld_source), ld_payload};
        end else if (state_q != TX_IDLE) begin
            beat_q  <= beat_q + 1'b1;
            frame_q <= frame_q << BYTE_W;
        end
    end

    always_comb begin
        ser_valid = (state_q != TX_IDLE);
        ser_byte  = frame_q[FRAME_W-1 -: BYTE_W];
    end

    AST_TX_START: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_ready) |=> ser_valid);                          // R2
    AST_TX_RUN: assert property (@(posedge clk) disable iff (rst)
        (ser_valid && !ld_ready) |=> ser_valid);                        // R4
    AST_TX_HDR_RSVD: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_HEAD) |-> (ser_byte[BYTE_W-1 -: RSV_W] == '0));  // R5

endmodule

// File: rtl/irq_deser_rx.sv
module irq_deser_rx
    import irq_link_pkg::*;
#(
    parameter int PAY_BYTES = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [BYTE_W-1:0]           rx_byte,
    input  logic                        rx_valid,
    output logic                        rx_done,
    output logic [HDR_W-1:0]            rx_header,
    output logic [PAY_BYTES*BYTE_W-1:0] rx_payload
);

    localparam int PAY_W       = PAY_BYTES * BYTE_W;
    localparam int FRAME_BYTES = HDR_BYTES + PAY_BYTES;
    localparam int FRAME_W     = FRAME_BYTES * BYTE_W;
    localparam int CNT_W       = $clog2(FRAME_BYTES);
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(FRAME_BYTES - 1);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BYTES - 1);

    rx_state_t                 state_q, state_d;
    logic [CNT_W-1:0]          cnt_q;
    logic [FRAME_W-BYTE_W-1:0] acc_q;
    logic [BYTE_W-1:0]         byte_in;
    logic [FRAME_W-1:0]        full;
    logic                      finish;
    logic                      done_q;
    logic [HDR_W-1:0]          hdr_q;
    logic [PAY_W-1:0]          pay_q;

    assign finish  = rx_valid && (cnt_q == LAST_BEAT);
    assign byte_in = (state_q == RX_HEAD) ? (rx_byte & HDR_KEEP) : rx_byte;
    assign full    = {acc_q, byte_in};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HEAD: if (rx_valid && cnt_q == HDR_LAST) state_d = RX_BODY;
            RX_BODY: if (finish) state_d = RX_HEAD;
            default: state_d = RX_HEAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RX_HEAD;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            done_q <= 1'b0;
            hdr_q  <= '0;
            pay_q  <= '0;
        end else begin
            done_q <= finish;
            if (rx_valid) begin
                acc_q <= full[FRAME_W-BYTE_W-1:0];
                cnt_q <= finish ? '0 : cnt_q + 1'b1;
            end
            if (finish) begin
                hdr_q <= full[FRAME_W-1 -: HDR_W];
                pay_q <= full[PAY_W-1:0];
            end
        end
    end

    always_comb begin
        rx_done    = done_q;
        rx_header  = hdr_q;
        rx_payload = pay_q;
    end

    AST_RX_GAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> $stable(cnt_q));                                  // R8
    AST_RX_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done);                                          // R9
    AST_RX_HDR_RSVD: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> (rx_header[HDR_W-1 -: RSV_W] == '0 &&
                     rx_header[BYTE_W-1 -: RSV_W] == '0));              // R10

endmodule

// File: rtl/irq_byte_link.sv
module irq_byte_link
    import irq_link_pkg::*;
#(
    parameter int PAY_BYTES = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ld_valid,
    output logic                        ld_ready,
    input  logic [FLD_W-1:0]            ld_target,
    input  logic [FLD_W-1:0]            ld_source,
    input  logic [PAY_BYTES*BYTE_W-1:0] ld_payload,
    output logic [BYTE_W-1:0]           ser_byte,
    output logic                        ser_valid,
    input  logic [BYTE_W-1:0]           rx_byte,
    input  logic                        rx_valid,
    output logic                        rx_done,
    output logic [HDR_W-1:0]            rx_header,
    output logic [PAY_BYTES*BYTE_W-1:0] rx_payload
);

    irq_ser_tx #(.PAY_BYTES(PAY_BYTES)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .ld_valid   (ld_valid),
        .ld_ready   (ld_ready),
        .ld_target  (ld_target),
        .ld_source  (ld_source),
        .ld_payload (ld_payload),
        .ser_byte   (ser_byte),
        .ser_valid  (ser_valid)
    );

    irq_deser_rx #(.PAY_BYTES(PAY_BYTES)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .rx_done    (rx_done),
        .rx_header  (rx_header),
        .rx_payload (rx_payload)
    );

endmodule

// File: tb/tb_irq_byte_link.sv
module tb_irq_byte_link;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ld_valid = 1'b0;
    logic         ld_ready;
    logic [4:0]   ld_target = '0;
    logic [4:0]   ld_source = '0;
    logic [127:0] ld_payload = '0;
    logic [7:0]   ser_byte;
    logic         ser_valid;
    logic [7:0]   rx_byte = '0;
    logic         rx_valid = 1'b0;
    logic         rx_done;
    logic [15:0]  rx_header;
    logic [127:0] rx_payload;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    logic [7:0] txq[$];
    logic [8:0] rxs[$];
    logic [7:0] got[$];
    logic         exp_done = 1'b0;
    logic [15:0]  exp_hdr  = '0;
    logic [127:0] exp_pay  = '0;

    irq_byte_link dut (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
        .ld_target(ld_target), .ld_source(ld_source), .ld_payload(ld_payload),
        .ser_byte(ser_byte), .ser_valid(ser_valid), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .rx_done(rx_done), .rx_header(rx_header),
        .rx_payload(rx_payload)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic push_rx_frame(input logic [7:0] h1, input logic [7:0] h2,
                                 input logic [127:0] p, input int gap_every);
        rxs.push_back({1'b1, h1});
        rxs.push_back({1'b1, h2});
        for (int i = 0; i < 16; i++) begin
            if (gap_every > 0 && (i % gap_every) == 0) begin
                rxs.push_back(9'h000);
                rxs.push_back(9'h000);
            end
            rxs.push_back({1'b1, p[127-8*i -: 8]});
        end
    endtask

    // one clock: compare outputs, drive receiver, advance reference model
    task automatic step();
        bit acc;
        chk(ld_ready == (txq.size() <= 1), "R2 R7 ld_ready", 128'(ld_ready),
            128'(txq.size() <= 1));
        chk(ser_valid == (txq.size() != 0), "R4 ser_valid", 128'(ser_valid),
            128'(txq.size() != 0));
        if (txq.size() != 0)
            chk(ser_byte == txq[0], "R3 R5 R6 ser_byte", 128'(ser_byte), 128'(txq[0]));
        chk(rx_done == exp_done, "R8 R9 rx_done", 128'(rx_done), 128'(exp_done));
        if (exp_done) begin
            chk(rx_header == exp_hdr, "R10 rx_header", 128'(rx_header), 128'(exp_hdr));
            chk(rx_payload == exp_pay, "R9 rx_payload", rx_payload, exp_pay);
        end
        if (rxs.size() != 0) {rx_valid, rx_byte} = rxs.pop_front();
        else begin rx_valid = 1'b0; rx_byte = 8'hA5; end
        acc = ld_valid && (txq.size() <= 1);
        @(posedge clk);
        if (txq.size() != 0) void'(txq.pop_front());
        if (acc) begin
            txq.push_back({3'b000, ld_target});
            txq.push_back({3'b000, ld_source});
            for (int i = 0; i < 16; i++) txq.push_back(ld_payload[127-8*i -: 8]);
        end
        exp_done = 1'b0;
        if (rx_valid) begin
            got.push_back(rx_byte);
            if (got.size() == 18) begin
                exp_done = 1'b1;
                exp_hdr  = {got[0] & 8'h1F, got[1] & 8'h1F};
                for (int i = 0; i < 16; i++) exp_pay[127-8*i -: 8] = got[2+i];
                got.delete();
            end
        end
        @(negedge clk);
    endtask

    function automatic logic [127:0] count_bytes(input logic [7:0] base);
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[127-8*i -: 8] = base + 8'(i);
        return v;
    endfunction

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state right after reset
        chk(ld_ready == 1'b1, "R1 ld_ready", 128'(ld_ready), 128'(1));
        chk(ser_valid == 1'b0, "R1 ser_valid", 128'(ser_valid), 128'(0));
        chk(rx_done == 1'b0, "R1 rx_done", 128'(rx_done), 128'(0));
        repeat (2) step();

        // single frame, counting pattern, extreme fields (R5, R6)
        ld_valid = 1'b1; ld_target = 5'h1F; ld_source = 5'h00;
        ld_payload = count_bytes(8'h01);
        step();
        ld_valid = 1'b0;
        repeat (22) step();

        // valid held through frames with changing data: R3 ignore, R7 back to back
        ld_valid = 1'b1; ld_target = 5'h00; ld_source = 5'h1F; ld_payload = '1;
        step();
        for (int i = 0; i < 40; i++) begin
            ld_target  = 5'(i);
            ld_source  = 5'(31 - i);
            ld_payload = (i < 20) ? {1'b1, 127'b0} : count_bytes(8'(8 * i));
            step();
        end
        ld_valid = 1'b0;
        repeat (25) step();

        // receiver: reserved bits set (R10), no gaps, then gapped (R8)
        push_rx_frame(8'hFF, 8'hE3, count_bytes(8'h40), 0);
        push_rx_frame(8'hA9, 8'h77, {1'b1, 127'b0}, 3);
        push_rx_frame(8'h1F, 8'hFF, '1, 1);
        rxs.push_back(9'h000);
        push_rx_frame(8'h20, 8'h01, count_bytes(8'hF0), 5);
        // transmitter runs alongside the receiver
        ld_valid = 1'b1; ld_target = 5'h15; ld_source = 5'h0A;
        ld_payload = count_bytes(8'h80);
        step();
        ld_valid = 1'b0;
        while (rxs.size() != 0) step();
        repeat (5) step();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule